// File: doc/BRIEF.md
# Opcode-Decoded 16-bit Arithmetic and Logic Unit

This unit carries out the arithmetic, bitwise, shift, rotate and byte-swap operations of a small 16-bit processor. The caller presents an 8-bit opcode with a destination operand and a source operand. The unit returns the 16-bit result in the same cycle. Selected fields of the opcode steer the datapath directly: bit 5 turns the adder into a subtractor, and bit 4 either substitutes the constant 1 for the source operand or, for shifts, chooses a plain rotate over a shift through carry.

A seven-bit flag register sits beside the datapath. On every clock edge where `valid_i` is high and the opcode belongs to the supported group, the unit rewrites only the flags that the operation affects. The carry bit of this register feeds the shift-through-carry operations. Opcodes outside the group raise `invalid_o`, pass the destination through unchanged and leave every flag alone.

Top module: `opc_alu`

## Requirements
- R1: While `rst_ni` is low, `flags_o` is all zeros. The flag bits are laid out as [0]=C (carry or borrow out of bit 15), [1]=QC (out of bit 3), [2]=HC (out of bit 7), [3]=TC (out of bit 11), [4]=Z (result zero), [5]=N (result bit 15), [6]=O (signed overflow).
- R2: Opcode 0x45 returns dst+src, 0x55 returns dst+1, 0x65 returns dst-src and 0x75 returns dst-1, all modulo 2^16.
- R3: After an add or increment, C holds the carry out of bit 15. After a subtract or decrement, C holds the borrow, which is 1 when the unsigned dst is smaller than the subtrahend.
- R4: After an arithmetic opcode, QC, HC and TC hold the carry (or borrow, for subtractive opcodes) out of bits 3, 7 and 11. This equals the carry or borrow of the same operation applied to the low 4, 8 and 12 bits.
- R5: After an arithmetic opcode, Z is 1 when the result is zero, N equals result bit 15, and O is 1 on two's-complement overflow.
- R6: Opcodes 0x40, 0x41, 0x42 and 0x43 return ~dst, dst^src, dst&src and dst|src. Each of these updates Z and leaves all other flags unchanged.
- R7: Opcode 0x46 returns {dst[14:0], C} and 0x47 returns {C, dst[15:1]}, using the carry held in the register. The bit shifted out becomes the new C. Z follows the result, and no other flag changes.
- R8: Opcodes 0x56 and 0x57 rotate dst left and right by one. Opcode 0x48 swaps the high and low bytes of dst. None of these three opcodes changes any flag.
- R9: Any other opcode drives `invalid_o` high, returns dst unchanged and changes no flag.
- R10: When `valid_i` is low, the flag register keeps its value whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Commit the operation's flag updates at the next edge |
| op_i | input | 8 | Operation code |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| res_o | output | 16 | Combinational result |
| invalid_o | output | 1 | Opcode is outside the supported group |
| flags_o | output | 7 | Flag register, layout as in R1 |

## Verification
A wrong flag mask shows up one edge after the faulty operation, when a flag that should have held its value changes. The bench checks every flag bit after every operation, so such a mask error is caught at the very next sample. A corrupted carry is more hidden: it shows immediately as a wrong C, but it also flows into the next shift-through-carry result. For that reason the sequences chain an operation that sets the carry with a shift that consumes it, so a stale or misrouted carry appears at `res_o` in the following cycle. Nibble carries and overflow are driven at their exact boundaries (0x000F+1, 0x7FFF+1, 0x8000-1, 0-1), where a carry tapped from the wrong bit gives a different value.

// File: rtl/opc_alu_pkg.sv
package opc_alu_pkg;
  localparam int unsigned FLAG_N = 7;
  localparam int unsigned F_C  = 0;
  localparam int unsigned F_QC = 1;
  localparam int unsigned F_HC = 2;
  localparam int unsigned F_TC = 3;
  localparam int unsigned F_Z  = 4;
  localparam int unsigned F_N  = 5;
  localparam int unsigned F_O  = 6;

  typedef enum logic [2:0] {
    K_ARITH, K_LOGIC, K_SHIFT, K_SWAP, K_NONE
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              sub;
    logic              use_one;
    logic              thru_c;
    logic              right;
    logic [1:0]        lsel;
    logic [FLAG_N-1:0] fmask;
    logic              invalid;
  } ctrl_t;
endpackage

// File: rtl/opc_alu_dec.sv
module opc_alu_dec
  import opc_alu_pkg::*;
(
  input  logic [7:0] op_i,
  output ctrl_t      ctrl_o
);
  localparam logic [FLAG_N-1:0] M_ALL  = '1;
  localparam logic [FLAG_N-1:0] M_Z    = FLAG_N'(1) << F_Z;
  localparam logic [FLAG_N-1:0] M_CZ   = (FLAG_N'(1) << F_Z) | (FLAG_N'(1) << F_C);
  localparam logic [FLAG_N-1:0] M_NONE = '0;

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.kind    = K_NONE;
    ctrl_o.sub     = op_i[5];
    ctrl_o.use_one = op_i[4];
    ctrl_o.thru_c  = ~op_i[4];
    ctrl_o.right   = op_i[0];
    ctrl_o.lsel    = op_i[1:0];
    ctrl_o.fmask   = M_NONE;
    ctrl_o.invalid = 1'b0;
    unique case (op_i)
      8'h45, 8'h55, 8'h65, 8'h75: begin
        ctrl_o.kind  = K_ARITH;
        ctrl_o.fmask = M_ALL;
      end
      8'h40, 8'h41, 8'h42, 8'h43: begin
        ctrl_o.kind  = K_LOGIC;
        ctrl_o.fmask = M_Z;
      end
      8'h46, 8'h47: begin
        ctrl_o.kind  = K_SHIFT;
        ctrl_o.fmask = M_CZ;
      end
      8'h56, 8'h57: ctrl_o.kind = K_SHIFT;
      8'h48:        ctrl_o.kind = K_SWAP;
      default:      ctrl_o.invalid = 1'b1;
    endcase
  end
endmodule

// File: rtl/opc_alu_arith.sv
module opc_alu_arith #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned NIB_N = DATA_W / NIB_W
) (
  input  logic              sub_i,
  input  logic              use_one_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NIB_N-1:0]  nib_cb_o,  // carry, or borrow when subtracting
  output logic              ovf_o
);
  logic [DATA_W-1:0] b_sel, b_x;
  logic [NIB_N:0]    cy;

  assign b_sel = use_one_i ? DATA_W'(1) : b_i;
  assign b_x   = sub_i ? ~b_sel : b_sel;
  assign cy[0] = sub_i;

  for (genvar i = 0; i < NIB_N; i++) begin : g_nib
    logic [NIB_W:0] part;
    assign part = {1'b0, a_i[i*NIB_W +: NIB_W]} + {1'b0, b_x[i*NIB_W +: NIB_W]}
                + {{NIB_W{1'b0}}, cy[i]};
    assign sum_o[i*NIB_W +: NIB_W] = part[NIB_W-1:0];
    assign cy[i+1]     = part[NIB_W];
    assign nib_cb_o[i] = part[NIB_W] ^ sub_i;
  end

  assign ovf_o = (a_i[DATA_W-1] == b_x[DATA_W-1]) && (sum_o[DATA_W-1] != a_i[DATA_W-1]);
endmodule

// File: rtl/opc_alu_logic.sv
module opc_alu_logic #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              thru_c_i,
  input  logic              right_i,
  input  logic [1:0]        lsel_i,
  input  logic              c_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] bit_o,
  output logic [DATA_W-1:0] shf_o,
  output logic              shf_c_o,
  output logic [DATA_W-1:0] swp_o
);
  logic fill;

  always_comb begin
    unique case (lsel_i)
      2'd0: bit_o = ~a_i;
      2'd1: bit_o = a_i ^ b_i;
      2'd2: bit_o = a_i & b_i;
      default: bit_o = a_i | b_i;
    endcase
  end

  // incoming bit: old carry for shifts, wrapped bit for rotates
  always_comb begin
    if (right_i) begin
      fill    = thru_c_i ? c_i : a_i[0];
      shf_o   = {fill, a_i[DATA_W-1:1]};
      shf_c_o = a_i[0];
    end else begin
      fill    = thru_c_i ? c_i : a_i[DATA_W-1];
      shf_o   = {a_i[DATA_W-2:0], fill};
      shf_c_o = a_i[DATA_W-1];
    end
  end

  assign swp_o = {a_i[HALF_W-1:0], a_i[DATA_W-1:HALF_W]};
endmodule

// File: rtl/opc_alu.sv
module opc_alu
  import opc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned NIB_N = DATA_W / NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              invalid_o,
  output logic [FLAG_N-1:0] flags_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] sum, bit_r, shf_r, swp_r;
  logic [NIB_N-1:0]  nib_cb;
  logic              ovf, shf_c;
  logic [FLAG_N-1:0] flags_q, flags_new;

  opc_alu_dec u_dec (
    .op_i  (op_i),
    .ctrl_o(ctrl)
  );

  opc_alu_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
    .sub_i    (ctrl.sub),
    .use_one_i(ctrl.use_one),
    .a_i      (dst_i),
    .b_i      (src_i),
    .sum_o    (sum),
    .nib_cb_o (nib_cb),
    .ovf_o    (ovf)
  );

  opc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .thru_c_i(ctrl.thru_c),
    .right_i (ctrl.right),
    .lsel_i  (ctrl.lsel),
    .c_i     (flags_q[F_C]),
    .a_i     (dst_i),
    .b_i     (src_i),
    .bit_o   (bit_r),
    .shf_o   (shf_r),
    .shf_c_o (shf_c),
    .swp_o   (swp_r)
  );

  always_comb begin
    unique case (ctrl.kind)
      K_ARITH: res_o = sum;
      K_LOGIC: res_o = bit_r;
      K_SHIFT: res_o = shf_r;
      K_SWAP:  res_o = swp_r;
      default: res_o = dst_i;
    endcase
  end

  always_comb begin
    flags_new       = '0;
    flags_new[F_C]  = (ctrl.kind == K_SHIFT) ? shf_c : nib_cb[NIB_N-1];
    flags_new[F_QC] = nib_cb[0];
    flags_new[F_HC] = nib_cb[1];
    flags_new[F_TC] = nib_cb[2];
    flags_new[F_Z]  = (res_o == '0);
    flags_new[F_N]  = res_o[DATA_W-1];
    flags_new[F_O]  = ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else if (valid_i && !ctrl.invalid)
      flags_q <= (flags_q & ~ctrl.fmask) | (flags_new & ctrl.fmask);
  end

  assign invalid_o = ctrl.invalid;
  assign flags_o   = flags_q;
endmodule

// File: rtl/opc_alu_chk.sv
module opc_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [7:0]  op_i,
  input logic [15:0] dst_i,
  input logic [15:0] res_o,
  input logic        invalid_o,
  input logic [6:0]  flags_o
);
  logic is_arith, is_logic, is_quiet;
  assign is_arith = (op_i == 8'h45) || (op_i == 8'h55) || (op_i == 8'h65) || (op_i == 8'h75);
  assign is_logic = (op_i[7:2] == 6'b010000);
  assign is_quiet = (op_i == 8'h56) || (op_i == 8'h57) || (op_i == 8'h48);

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o)); // R10
  AST_INVALID_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> res_o == dst_i); // R9
  AST_INVALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && invalid_o |=> $stable(flags_o)); // R9
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_quiet |=> $stable(flags_o)); // R8
  AST_LOGIC_ZONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_logic |=> $stable(flags_o[3:0]) && $stable(flags_o[6:5])); // R6
  AST_ARITH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_arith |=> flags_o[4] == ($past(res_o) == 16'h0)); // R5
  AST_ARITH_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_arith |=> flags_o[5] == $past(res_o[15])); // R5
endmodule

bind opc_alu opc_alu_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .dst_i    (dst_i),
  .res_o    (res_o),
  .invalid_o(invalid_o),
  .flags_o  (flags_o)
);

// File: tb/opc_alu_tb.sv
module opc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  op_i = 8'hFF;
  logic [15:0] dst_i = '0, src_i = '0;
  logic [15:0] res_o;
  logic        invalid_o;
  logic [6:0]  flags_o;

  int checks = 0, errors = 0;
  logic [6:0] model_f = '0;
  bit done = 0;

  typedef struct {
    logic [15:0] r;
    logic        inv;
    logic [6:0]  f;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  opc_alu u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .res_o(res_o), .invalid_o(invalid_o),
    .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model: flag layout [0]C [1]QC [2]HC [3]TC [4]Z [5]N [6]O
  task automatic model(input logic [7:0] op, input logic [15:0] a, b, input logic [6:0] fi,
                       output logic [15:0] r, output logic inv, output logic [6:0] fo);
    logic [15:0] bb;
    int sa, sb, d;
    fo = fi; inv = 0; r = a;
    bb = op[4] ? 16'd1 : b;
    sa = int'($signed(a)); sb = int'($signed(bb));
    case (op)
      8'h45, 8'h55: begin
        r = a + bb; d = sa + sb;
        fo[0] = ({1'b0, a} + {1'b0, bb}) > 17'hFFFF;
        fo[1] = ({1'b0, a[3:0]} + {1'b0, bb[3:0]}) > 5'hF;
        fo[2] = ({1'b0, a[7:0]} + {1'b0, bb[7:0]}) > 9'hFF;
        fo[3] = ({1'b0, a[11:0]} + {1'b0, bb[11:0]}) > 13'hFFF;
        fo[4] = (r == 0); fo[5] = r[15]; fo[6] = (d > 32767) || (d < -32768);
      end
      8'h65, 8'h75: begin
        r = a - bb; d = sa - sb;
        fo[0] = a < bb; fo[1] = a[3:0] < bb[3:0];
        fo[2] = a[7:0] < bb[7:0]; fo[3] = a[11:0] < bb[11:0];
        fo[4] = (r == 0); fo[5] = r[15]; fo[6] = (d > 32767) || (d < -32768);
      end
      8'h40: begin r = ~a;    fo[4] = (r == 0); end
      8'h41: begin r = a ^ b; fo[4] = (r == 0); end
      8'h42: begin r = a & b; fo[4] = (r == 0); end
      8'h43: begin r = a | b; fo[4] = (r == 0); end
      8'h46: begin r = {a[14:0], fi[0]}; fo[0] = a[15]; fo[4] = (r == 0); end
      8'h47: begin r = {fi[0], a[15:1]}; fo[0] = a[0];  fo[4] = (r == 0); end
      8'h56: r = {a[14:0], a[15]};
      8'h57: r = {a[0], a[15:1]};
      8'h48: r = {a[7:0], a[15:8]};
      default: inv = 1;
    endcase
  endtask

  task automatic drive(input string tag, input logic [7:0] op, input logic [15:0] a, b,
                       input logic v = 1'b1);
    item_t it;
    logic [6:0] fo;
    @(negedge clk); #1;
    op_i = op; dst_i = a; src_i = b; valid_i = v;
    model(op, a, b, model_f, it.r, it.inv, fo);
    if (v) model_f = fo;
    it.f = model_f; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: result mid-cycle, flags one cycle later
  initial begin
    item_t pend;
    bit have = 0;
    forever begin
      @(negedge clk); #5;
      if (have) chk({pend.tag, " flags"}, 32'(flags_o), 32'(pend.f));
      have = 0;
      if (q.size() > 0) begin
        pend = q.pop_front();
        chk({pend.tag, " res"}, 32'(res_o), 32'(pend.r));
        chk({pend.tag, " invalid"}, 32'(invalid_o), 32'(pend.inv));
        have = 1;
      end
    end
  end

  initial begin
    #35;
    chk("R1 reset flags", 32'(flags_o), 32'h0);
    @(negedge clk); rst_ni = 1'b1;
    // R2 R3 R4 R5 add, inc, sub, dec at boundaries
    drive("R2 add", 8'h45, 16'h1234, 16'h1111);
    drive("R4 add nibble", 8'h45, 16'h000F, 16'h0001);
    drive("R5 add ovf", 8'h45, 16'h7FFF, 16'h0001);
    drive("R3 add carry", 8'h45, 16'hFFFF, 16'h0001);
    // R7 shift consumes carry from previous op
    drive("R7 lsl thru c", 8'h46, 16'h8001, 16'h0);
    drive("R7 lsr thru c", 8'h47, 16'h0002, 16'h0);
    drive("R2 inc", 8'h55, 16'h00FF, 16'hABCD);
    drive("R3 sub", 8'h65, 16'h0005, 16'h0003);
    drive("R4 sub borrow", 8'h65, 16'h0010, 16'h0001);
    drive("R5 sub ovf", 8'h65, 16'h8000, 16'h0001);
    drive("R3 dec zero", 8'h75, 16'h0000, 16'h1234);
    drive("R5 sub zero", 8'h65, 16'h4321, 16'h4321);
    drive("R2 dec", 8'h75, 16'h1000, 16'h0);
    // R6 logic group, only Z touched
    drive("R6 not", 8'h40, 16'hFFFF, 16'h0);
    drive("R6 xor", 8'h41, 16'hF0F0, 16'h0FF0);
    drive("R6 and", 8'h42, 16'hF0F0, 16'h0F0F);
    drive("R6 or", 8'h43, 16'h00F0, 16'h0F00);
    drive("R3 sub set c", 8'h65, 16'h0000, 16'h0001);
    drive("R7 lsr c out", 8'h47, 16'h0001, 16'h0);
    drive("R7 lsl zero", 8'h46, 16'h8000, 16'h0);
    // R8 rotate and swap, no flags
    drive("R8 rol", 8'h56, 16'h8001, 16'h0);
    drive("R8 ror", 8'h57, 16'h8001, 16'h0);
    drive("R8 swap", 8'h48, 16'h12AB, 16'h0);
    // R9 invalid
    drive("R9 invalid", 8'hC0, 16'hBEEF, 16'h0);
    drive("R9 invalid 44", 8'h44, 16'h0000, 16'h0);
    // R10 valid low
    drive("R10 idle add", 8'h45, 16'hFFFF, 16'h0001, 1'b0);
    drive("R10 idle lsr", 8'h47, 16'h0001, 16'h0, 1'b0);
    drive("R2 add tail", 8'h45, 16'h0001, 16'h0002);
    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #200000; errors++; $display("FAIL watchdog expired"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule